// File: doc/BRIEF.md
# Multi-Lane Horizontal Path Cost Estimator

This block serves a semi-global stereo matcher that takes several pixels of one image line in each clock. On the horizontal path, every pixel's path-cost update needs the path cost of the pixel just to its left. When several pixels share one clock, that need would chain the per-pixel updates in series inside a single cycle. The block breaks the chain. For every lane of the incoming pixel vector, it supplies the "previous pixel" path-cost vector that the lane's own update unit consumes. The update units themselves sit outside the block.

The first lane gets the exact value: the path cost that the last lane of the previous vector produced, which the block holds in a register. Every later lane gets an estimate. The estimate starts from that held cost and moves it toward a running average of the matching costs of the pixels in front of the lane in the current vector. The step is scaled by 1/2^LAMBDA_LOG2, so the only arithmetic involved is adds, subtracts and shifts. The same circuit is repeated for every disparity, and each disparity is independent of the others.

A vector flagged as the first of a line treats the held cost as zero, so no cost carries over from the previous line.

Top module: `hpathEstimator`

## Requirements
- R1: Lane 0 (the first pixel) outputs, per disparity, the `lastPathIn` value captured at the most recent clock edge where `vecValid` was high, unless R6 applies.
- R2: Lane 1 outputs L + floor((C0 − L) / 2^LAMBDA_LOG2). L is lane 0's held value and C0 is lane 0's matching cost for the same disparity.
- R3: Lane 2 outputs L + floor((A1 − L) / 2^LAMBDA_LOG2), where A1 = floor((C0 + C1) / 2).
- R4: Lane 3 outputs L + floor((A2 − L) / 2^LAMBDA_LOG2), where A2 = floor((A1 + C2) / 2).
- R5: The difference is signed and the shift rounds toward minus infinity, so a cost below L moves the estimate down by at least one whenever the difference is nonzero. Each estimate lies between L and its average, inclusive, and is never negative.
- R6: In a cycle where `vecValid` and `lineStart` are both high, L is taken as zero for every lane and disparity of that vector.
- R7: While `vecValid` is low, the held cost does not change, and `lineStart` has no effect on the outputs.
- R8: After reset, the held cost is zero for every disparity.
- R9: Each disparity's outputs depend only on that disparity's costs and held value.
- R10: With LAMBDA_LOG2 = 0, every estimate equals its average: lane 1 gets C0, lane 2 gets A1 and lane 3 gets A2.

Port packing: in `costIn`, lane l and disparity d sit at bit offset (l·NDISP + d)·COST_W, for lanes 0 to LANES−2. In `prevPathOut`, lane l and disparity d sit at offset (l·NDISP + d)·PATH_W. The last pixel's own matching cost is not needed, so it has no port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vecValid | input | 1 | A pixel vector is present this cycle; the held cost loads at the edge |
| lineStart | input | 1 | The present vector is the first of a line (qualified by `vecValid`) |
| costIn | input | (LANES−1)·NDISP·COST_W | Matching costs of every lane except the last |
| lastPathIn | input | NDISP·PATH_W | Horizontal path cost computed for the last lane of the present vector |
| prevPathOut | output | LANES·NDISP·PATH_W | Previous-pixel path cost supplied to each lane |

## Verification
The hardest case to reach is a large held cost meeting small matching costs. In that case the signed difference is negative, and floor rounding differs from truncation by exactly one. The stimulus therefore loads a held value of 1 and then presents zero costs, and it also loads a held value of 1023 against small costs. Three instances with different shift amounts see the same vectors, so the rounding is exercised at several weights. A cycle with `lineStart` raised while `vecValid` is low is placed between two valid vectors, to show that the held cost survives it.

// File: rtl/hpathEstPkg.sv
package hpathEstPkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic useZero;   // treat the held cost as zero for this vector
    logic capture;   // load the held cost at the next edge
  } estStrobe_t;

endpackage

// File: rtl/hpathEstCtrl.sv
module hpathEstCtrl
  import hpathEstPkg::*;
(
  input  logic       vecValid,
  input  logic       lineStart,
  output estStrobe_t strobes
);

  always_comb begin
    strobes         = '0;
    strobes.capture = vecValid;
    strobes.useZero = vecValid & lineStart;
  end

endmodule

// File: rtl/hpathEstCell.sv
module hpathEstCell #(
  parameter int LANES       = 4,
  parameter int COST_W      = 5,
  parameter int PATH_W      = 10,
  parameter int LAMBDA_LOG2 = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PATH_W-1:0]            lastCost,
  input  logic [(LANES-1)*COST_W-1:0]  laneCost,
  output logic [LANES*PATH_W-1:0]      prevCost
);

  localparam int DIFF_W = PATH_W + 2;

  // Running averages of the costs ahead of each lane
  logic [COST_W-1:0] runAvg [LANES-1];

  assign runAvg[0] = laneCost[0 +: COST_W];

  for (genvar k = 1; k < LANES - 1; k++) begin : g_avg
    logic [COST_W:0] pairSum;
    assign pairSum   = {1'b0, runAvg[k-1]} + {1'b0, laneCost[k*COST_W +: COST_W]};
    assign runAvg[k] = pairSum[COST_W:1];
  end

  assign prevCost[0 +: PATH_W] = lastCost;

  for (genvar j = 1; j < LANES; j++) begin : g_lane
    logic        [PATH_W-1:0] target;
    logic signed [DIFF_W-1:0] gap;
    logic signed [DIFF_W-1:0] stepVal;
    logic signed [DIFF_W-1:0] blend;
    logic        [PATH_W-1:0] estimate;
    logic        [PATH_W-1:0] boundLo;
    logic        [PATH_W-1:0] boundHi;

    always_comb begin
      target  = PATH_W'(runAvg[j-1]);
      gap     = $signed({2'b00, target}) - $signed({2'b00, lastCost});
      stepVal = gap >>> LAMBDA_LOG2;
      blend   = $signed({2'b00, lastCost}) + stepVal;
      if (blend[DIFF_W-1])
        estimate = '0;
      else if (|blend[DIFF_W-2:PATH_W])
        estimate = '1;
      else
        estimate = blend[PATH_W-1:0];
      boundLo = (target < lastCost) ? target : lastCost;
      boundHi = (target < lastCost) ? lastCost : target;
    end

    assign prevCost[j*PATH_W +: PATH_W] = estimate;

    // R5: estimate stays between held cost and average
    p_est_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prevCost[j*PATH_W +: PATH_W] >= boundLo) && (prevCost[j*PATH_W +: PATH_W] <= boundHi));

    if (LAMBDA_LOG2 == 0) begin : g_unity
      // R10: unity weight takes the average directly
      p_unity_weight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prevCost[j*PATH_W +: PATH_W] == target);
    end
  end

endmodule

// File: rtl/hpathEstDatapath.sv
module hpathEstDatapath
  import hpathEstPkg::*;
#(
  parameter int LANES       = 4,
  parameter int NDISP       = 8,
  parameter int COST_W      = 5,
  parameter int PATH_W      = 10,
  parameter int LAMBDA_LOG2 = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  estStrobe_t                         strobes,
  input  logic [(LANES-1)*NDISP*COST_W-1:0]  costIn,
  input  logic [NDISP*PATH_W-1:0]            lastPathIn,
  output logic [LANES*NDISP*PATH_W-1:0]      prevPathOut
);

  localparam int CELL_IN_W  = (LANES - 1) * COST_W;
  localparam int CELL_OUT_W = LANES * PATH_W;

  for (genvar d = 0; d < NDISP; d++) begin : g_disp
    logic [PATH_W-1:0]     heldCost;
    logic [PATH_W-1:0]     effCost;
    logic [CELL_IN_W-1:0]  cellCost;
    logic [CELL_OUT_W-1:0] cellOut;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        heldCost <= '0;
      else if (strobes.capture)
        heldCost <= lastPathIn[d*PATH_W +: PATH_W];
    end

    assign effCost = strobes.useZero ? '0 : heldCost;

    for (genvar l = 0; l < LANES - 1; l++) begin : g_gather
      assign cellCost[l*COST_W +: COST_W] = costIn[(l*NDISP + d)*COST_W +: COST_W];
    end

    hpathEstCell #(
      .LANES      (LANES),
      .COST_W     (COST_W),
      .PATH_W     (PATH_W),
      .LAMBDA_LOG2(LAMBDA_LOG2)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .lastCost (effCost),
      .laneCost (cellCost),
      .prevCost (cellOut)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_scatter
      assign prevPathOut[(l*NDISP + d)*PATH_W +: PATH_W] = cellOut[l*PATH_W +: PATH_W];
    end

    // R1: first lane follows the cost captured at the previous valid edge
    p_lane0_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(strobes.capture) && !strobes.useZero)
      |-> prevPathOut[d*PATH_W +: PATH_W] == $past(lastPathIn[d*PATH_W +: PATH_W]));

    // R6: line start forces a zero held cost
    p_line_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.useZero |-> prevPathOut[d*PATH_W +: PATH_W] == '0);

    // R7: no valid vector, no change of the held cost
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(strobes.capture) && !strobes.useZero)
      |-> $stable(prevPathOut[d*PATH_W +: PATH_W]));

    // R8: held cost is zero right after reset
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n)) |-> heldCost == '0);
  end

endmodule

// File: rtl/hpathEstimator.sv
module hpathEstimator
  import hpathEstPkg::*;
#(
  parameter int LANES       = 4,
  parameter int NDISP       = 8,
  parameter int COST_W      = 5,
  parameter int PATH_W      = 10,
  parameter int LAMBDA_LOG2 = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               vecValid,
  input  logic                               lineStart,
  input  logic [(LANES-1)*NDISP*COST_W-1:0]  costIn,
  input  logic [NDISP*PATH_W-1:0]            lastPathIn,
  output logic [LANES*NDISP*PATH_W-1:0]      prevPathOut
);

  estStrobe_t strobes;

  hpathEstCtrl u_ctrl (
    .vecValid (vecValid),
    .lineStart(lineStart),
    .strobes  (strobes)
  );

  hpathEstDatapath #(
    .LANES      (LANES),
    .NDISP      (NDISP),
    .COST_W     (COST_W),
    .PATH_W     (PATH_W),
    .LAMBDA_LOG2(LAMBDA_LOG2)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .costIn     (costIn),
    .lastPathIn (lastPathIn),
    .prevPathOut(prevPathOut)
  );

endmodule

// File: tb/hpathEstimator_test.sv
module hpathEstimator_test;

  localparam int LANES  = 4;
  localparam int NDISP  = 8;
  localparam int COST_W = 5;
  localparam int PATH_W = 10;
  localparam int CMAX   = 1 << COST_W;
  localparam int PMAX   = 1 << PATH_W;
  localparam int OUT_W  = LANES * NDISP * PATH_W;

  // Table: lineStart, lane costs base, cost step per disparity, held base, held step
  localparam int NVEC = 8;
  localparam int tLine  [NVEC] = '{1, 0, 0, 0, 1, 0, 0, 0};
  localparam int tB0    [NVEC] = '{3, 31, 0, 12, 31, 7, 0, 29};
  localparam int tB1    [NVEC] = '{20, 0, 0, 12, 31, 25, 0, 4};
  localparam int tB2    [NVEC] = '{9, 17, 0, 12, 31, 2, 0, 18};
  localparam int tCStep [NVEC] = '{5, 3, 0, 0, 0, 11, 0, 7};
  localparam int tLBase [NVEC] = '{600, 40, 1023, 12, 0, 1, 1, 511};
  localparam int tLStep [NVEC] = '{97, 13, 0, 0, 0, 0, 101, 59};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vecValid = 1'b0;
  logic lineStart = 1'b0;
  logic [(LANES-1)*NDISP*COST_W-1:0] costIn = '0;
  logic [NDISP*PATH_W-1:0] lastPathIn = '0;
  logic [OUT_W-1:0] outMain, outFlat, outSlow;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int modelL [NDISP];
  int curCost [LANES-1][NDISP];

  always #10 clk = ~clk;

  hpathEstimator #(.LANES(LANES), .NDISP(NDISP), .COST_W(COST_W), .PATH_W(PATH_W), .LAMBDA_LOG2(2)) uut (
    .clk(clk), .rst_n(rst_n), .vecValid(vecValid), .lineStart(lineStart),
    .costIn(costIn), .lastPathIn(lastPathIn), .prevPathOut(outMain));

  hpathEstimator #(.LANES(LANES), .NDISP(NDISP), .COST_W(COST_W), .PATH_W(PATH_W), .LAMBDA_LOG2(0)) uutFlat (
    .clk(clk), .rst_n(rst_n), .vecValid(vecValid), .lineStart(lineStart),
    .costIn(costIn), .lastPathIn(lastPathIn), .prevPathOut(outFlat));

  hpathEstimator #(.LANES(LANES), .NDISP(NDISP), .COST_W(COST_W), .PATH_W(PATH_W), .LAMBDA_LOG2(3)) uutSlow (
    .clk(clk), .rst_n(rst_n), .vecValid(vecValid), .lineStart(lineStart),
    .costIn(costIn), .lastPathIn(lastPathIn), .prevPathOut(outSlow));

  function automatic int refEst(int last, int tgt, int s);
    int diff = tgt - last;
    int div = 1 << s;
    int q;
    int r;
    if (diff >= 0) q = diff / div;
    else q = -((-diff + div - 1) / div);
    r = last + q;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic checkOut(input logic [OUT_W-1:0] outv, input int s, input string who, input string ctx);
    for (int l = 0; l < LANES; l++) begin
      int bad = 0;
      int gotV = 0;
      int expV = 0;
      int badD = 0;
      string tag;
      case (l)
        0: tag = "R1";
        1: tag = "R2";
        2: tag = "R3";
        default: tag = "R4";
      endcase
      for (int d = 0; d < NDISP; d++) begin
        int lEff = (vecValid && lineStart) ? 0 : modelL[d];
        int a1 = (curCost[0][d] + curCost[1][d]) / 2;
        int a2 = (a1 + curCost[2][d]) / 2;
        int e;
        int g = int'(outv[(l*NDISP + d)*PATH_W +: PATH_W]);
        case (l)
          0: e = lEff;
          1: e = refEst(lEff, curCost[0][d], s);
          2: e = refEst(lEff, a1, s);
          default: e = refEst(lEff, a2, s);
        endcase
        if (g != e && bad == 0) begin
          bad = 1; gotV = g; expV = e; badD = d;
        end
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s %s inst=%s lane=%0d disp=%0d actual=%0d expected=%0d",
                 tag, ctx, who, l, badD, gotV, expV);
      end
    end
  endtask

  task automatic applyVec(input int valid, input int line, input int b0, input int b1, input int b2,
                          input int cStep, input int lBase, input int lStep, input string ctx);
    @(negedge clk);
    vecValid  = valid[0];
    lineStart = line[0];
    for (int d = 0; d < NDISP; d++) begin
      curCost[0][d] = (b0 + d * cStep) % CMAX;
      curCost[1][d] = (b1 + d * cStep * 3) % CMAX;
      curCost[2][d] = (b2 + d * cStep * 5) % CMAX;
      for (int l = 0; l < LANES - 1; l++)
        costIn[(l*NDISP + d)*COST_W +: COST_W] = COST_W'(curCost[l][d]);
      lastPathIn[d*PATH_W +: PATH_W] = PATH_W'((lBase + d * lStep) % PMAX);
    end
    #2;
    checkOut(outMain, 2, "uut", ctx);
    checkOut(outFlat, 0, "uutFlat", {ctx, " R10"});
    checkOut(outSlow, 3, "uutSlow", ctx);
    if (valid != 0)
      for (int d = 0; d < NDISP; d++) modelL[d] = (lBase + d * lStep) % PMAX;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDISP; d++) modelL[d] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: held cost is zero after reset, seen through lane 0 on a plain vector
    applyVec(1, 0, 5, 9, 30, 2, 300, 17, "R8 reset");

    // Table walk: R9 per-disparity independence via varying steps
    for (int i = 0; i < NVEC; i++)
      applyVec(1, tLine[i], tB0[i], tB1[i], tB2[i], tCStep[i], tLBase[i], tLStep[i], "R9 table");

    // R7: invalid cycle with lineStart high and new held input is ignored
    applyVec(1, 0, 10, 20, 30, 1, 777, 3, "R7 load");
    applyVec(0, 1, 1, 2, 3, 0, 5, 0, "R7 idle");
    applyVec(1, 0, 4, 4, 4, 0, 100, 0, "R7 held");

    // R5: held value 1 against zero costs, floor rounding must reach 0
    applyVec(1, 0, 0, 0, 0, 0, 1, 0, "R5 load one");
    applyVec(1, 0, 0, 0, 0, 0, 1023, 0, "R5 floor");
    // R5: maximum held value against mid costs
    applyVec(1, 0, 3, 17, 8, 0, 0, 0, "R5 large gap");

    // R6: line start mid-stream zeroes the held cost
    applyVec(1, 1, 31, 31, 31, 0, 200, 0, "R6 line");
    applyVec(1, 0, 0, 31, 0, 1, 0, 0, "R6 after");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule